// File: doc/BRIEF.md
# Three-Port Open-Drain GPIO Register Controller

This block controls three 8-bit general-purpose I/O ports. It is reached over a simple synchronous register bus. Each port has a latch register and a direction register. A direction bit picks input or output mode for its pin. In output mode the pin is open-drain: a latch bit of 0 pulls the pad low, and a latch bit of 1 releases it. In input mode the latch bit does not drive the pin. It selects the on-chip pull-up instead: the pull-up is on when the latch bit is 0 and off when it is 1.

Pin inputs pass through a two-flop synchronizer. A read of a latch address returns a mix per bit: the synchronized pad level for input bits and the stored latch bit for output bits. A write always lands in the latch, whatever the direction. Software that does a read-modify-write of one bit can therefore change the pull-up choice of neighbouring input bits. This is deliberate and is kept.

Port bits appear flattened on the pin buses: port A on bits 7:0, port B on bits 15:8 and port C on bits 23:16. Read data is registered.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, the latch and direction registers of ports A and B hold 00h. Port C's latch and direction registers both hold 04h, so pin 2 of port C (bus bit 18) is an output with its drive released.
- R2: The direction registers sit at C4h (A), C5h (B) and C6h (C). Reading one returns exactly the value last written or reset into it. A direction bit of 1 selects output mode and 0 selects input mode.
- R3: For a pin in input mode, `pin_pu_en` is 1 when its latch bit is 0 and 0 when its latch bit is 1. `pin_oe` and `pin_out` are both 0.
- R4: For a pin in output mode, `pin_pu_en` is 0, `pin_out` equals the latch bit, and `pin_oe` is 1 only when the latch bit is 0 (open-drain pull low). `pin_oe` and `pin_out` are never both 1.
- R5: The latch registers sit at C0h (A), C1h (B) and C2h (C). A read returns the synchronized pad level for each input-mode bit and the latch bit for each output-mode bit.
- R6: A pad level reaches read data through two synchronizer flops. A read strobe sampled at the third rising edge after a pad change returns the new level.
- R7: A latch write updates all eight latch bits regardless of direction. A read-modify-write therefore changes the pull-up state of input bits whose pad level differs from the latch.
- R8: Reads of any other address return 00h. Writes to any other address change no register and no pin output.
- R9: `bus_rdata` is updated on the rising edge that samples `bus_rd`, and it holds its value while `bus_rd` is low.
- R10: A write takes effect on the rising edge that samples `bus_wr`. A read of the same address sampled at that same edge returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Raw pad levels, port A in bits 7:0 |
| pin_oe | output | 24 | Pad drive enable (drives low when set) |
| pin_out | output | 24 | Output-mode latch value per pin |
| pin_pu_en | output | 24 | Pull-up enable per pin |

## Verification
On every cycle, the assertions check that no pin both drives and pulls up, and that the drive is never active with a high output value. After each bus access they also check several things: the effect of a direction write or a latch write on the pull-up and drive enables, zero read data from unmapped addresses, that read data holds between strobes, and that the synchronizer delays pad levels by exactly two cycles. Other behaviours can only be shown by the bench's scenarios: the reset contents, the per-bit mix of pad level and latch on readback, read-during-write ordering, and how a one-bit read-modify-write changes neighbouring pull-ups. The bench models all six registers and compares them under random traffic mixed with those directed cases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Width of one port in bits.
    localparam int unsigned PORT_W = 8;

    // Two-flop synchronizer stage pair.
    typedef struct packed {
        logic [PORT_W-1:0] meta;
        logic [PORT_W-1:0] stable;
    } sync_state_t;

    // Register state of one port.
    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
    } port_regs_t;

    // Pin control signals derived for one port.
    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] pu;
    } pin_ctrl_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] raw_in,
    output logic [PORT_W-1:0] sync_out
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter logic [PORT_W-1:0] RST_LATCH = '0,
    parameter logic [PORT_W-1:0] RST_DIR   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_latch,
    input  logic              wr_dir,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // A latch write lands regardless of the direction bits.
        if (wr_latch) regs_d.latch = wdata;
        if (wr_dir)   regs_d.dir   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.latch <= RST_LATCH;
            regs_q.dir   <= RST_DIR;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign latch_q = regs_q.latch;
    assign dir_q   = regs_q.dir;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
(
    input  logic [PORT_W-1:0] latch,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] pad_sync,
    output logic [PORT_W-1:0] oe,
    output logic [PORT_W-1:0] out,
    output logic [PORT_W-1:0] pu,
    output logic [PORT_W-1:0] readback
);
    pin_ctrl_t ctl;

    always_comb begin
        ctl = '0;
        for (int b = 0; b < PORT_W; b++) begin
            if (dir[b]) begin
                // Open-drain output: only a zero actively drives the pad.
                ctl.oe[b]  = ~latch[b];
                ctl.out[b] = latch[b];
                ctl.pu[b]  = 1'b0;
            end else begin
                // Input: the latch bit chooses the pull-up (0 = on).
                ctl.oe[b]  = 1'b0;
                ctl.out[b] = 1'b0;
                ctl.pu[b]  = ~latch[b];
            end
            readback[b] = dir[b] ? latch[b] : pad_sync[b];
        end
    end

    assign oe  = ctl.oe;
    assign out = ctl.out;
    assign pu  = ctl.pu;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] LATCH_BASE = 8'hC0,
    parameter logic [ADDR_W-1:0] DIR_BASE   = 8'hC4,
    parameter logic [NUM_PORTS*PORT_W-1:0] RST_LATCH = 24'h04_00_00,
    parameter logic [NUM_PORTS*PORT_W-1:0] RST_DIR   = 24'h04_00_00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [PORT_W-1:0]           bus_wdata,
    input  logic                        bus_rd,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out,
    output logic [NUM_PORTS*PORT_W-1:0] pin_pu_en
);
    localparam int unsigned TOTAL_W = NUM_PORTS * PORT_W;

    logic [NUM_PORTS-1:0] hit_latch, hit_dir;
    logic [PORT_W-1:0]    rb_val  [NUM_PORTS];
    logic [PORT_W-1:0]    dir_val [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] A_LATCH = LATCH_BASE + ADDR_W'(p);
        localparam logic [ADDR_W-1:0] A_DIR   = DIR_BASE + ADDR_W'(p);

        logic [PORT_W-1:0] pad_sync, latch_q, dir_q;

        assign hit_latch[p] = (bus_addr == A_LATCH);
        assign hit_dir[p]   = (bus_addr == A_DIR);

        gpio_sync i_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (pin_in[p*PORT_W +: PORT_W]),
            .sync_out (pad_sync)
        );

        gpio_port_regs #(
            .RST_LATCH (RST_LATCH[p*PORT_W +: PORT_W]),
            .RST_DIR   (RST_DIR[p*PORT_W +: PORT_W])
        ) i_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_latch (bus_wr && hit_latch[p]),
            .wr_dir   (bus_wr && hit_dir[p]),
            .wdata    (bus_wdata),
            .latch_q  (latch_q),
            .dir_q    (dir_q)
        );

        gpio_pin_ctrl i_ctrl (
            .latch    (latch_q),
            .dir      (dir_q),
            .pad_sync (pad_sync),
            .oe       (pin_oe[p*PORT_W +: PORT_W]),
            .out      (pin_out[p*PORT_W +: PORT_W]),
            .pu       (pin_pu_en[p*PORT_W +: PORT_W]),
            .readback (rb_val[p])
        );

        assign dir_val[p] = dir_q;
    end

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        logic [PORT_W-1:0] sel;
        sel  = '0;
        rd_d = rd_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit_latch[p]) sel = sel | rb_val[p];
            if (hit_dir[p])   sel = sel | dir_val[p];
        end
        // Unmapped addresses leave sel at zero.
        if (bus_rd) rd_d.rdata = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    logic unused_w;
    assign unused_w = ^TOTAL_W;
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] LATCH_BASE = 8'hC0,
    parameter logic [ADDR_W-1:0] DIR_BASE   = 8'hC4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic [PORT_W-1:0]           bus_wdata,
    input logic                        bus_rd,
    input logic [PORT_W-1:0]           bus_rdata,
    input logic [NUM_PORTS*PORT_W-1:0] pin_in,
    input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    input logic [NUM_PORTS*PORT_W-1:0] pin_out,
    input logic [NUM_PORTS*PORT_W-1:0] pin_pu_en,
    input logic [PORT_W-1:0]           sync_a
);
    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == LATCH_BASE + ADDR_W'(p)) mapped = 1'b1;
            if (bus_addr == DIR_BASE + ADDR_W'(p))   mapped = 1'b1;
        end
    end

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r4_no_drive_and_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_pu_en) == '0);

    a_r4_drive_only_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out) == '0);

    a_r2_dir_write_kills_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_BASE) |=> (pin_pu_en[PORT_W-1:0] & $past(bus_wdata)) == '0);

    a_r7_latch_ones_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LATCH_BASE)
        |=> ((pin_pu_en[PORT_W-1:0] | pin_oe[PORT_W-1:0]) & $past(bus_wdata)) == '0);

    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> bus_rdata == '0);

    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r6_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> sync_a == $past(pin_in[PORT_W-1:0], 2));
endmodule

bind gpio_ctrl gpio_ctrl_checker #(
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_W     (ADDR_W),
    .LATCH_BASE (LATCH_BASE),
    .DIR_BASE   (DIR_BASE)
) i_gpio_ctrl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_pu_en (pin_pu_en),
    .sync_a    (g_port[0].pad_sync)
);

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] pin_in = '0;
    logic [23:0] pin_oe, pin_out, pin_pu_en;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_latch [3];
    logic [7:0]  m_dir   [3];

    always #5 clk = ~clk;

    gpio_ctrl i_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu_en(pin_pu_en)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        for (int p = 0; p < 3; p++) begin
            if (a == 8'hC0 + 8'(p))
                return (m_dir[p] & m_latch[p]) | (~m_dir[p] & pin_in[p*8 +: 8]);
            if (a == 8'hC4 + 8'(p))
                return m_dir[p];
        end
        return 8'h00;
    endfunction

    function automatic logic [23:0] exp_pu();
        logic [23:0] v;
        for (int p = 0; p < 3; p++) v[p*8 +: 8] = ~m_dir[p] & ~m_latch[p];
        return v;
    endfunction

    function automatic logic [23:0] exp_oe();
        logic [23:0] v;
        for (int p = 0; p < 3; p++) v[p*8 +: 8] = m_dir[p] & ~m_latch[p];
        return v;
    endfunction

    function automatic logic [23:0] exp_out();
        logic [23:0] v;
        for (int p = 0; p < 3; p++) v[p*8 +: 8] = m_dir[p] & m_latch[p];
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        for (int p = 0; p < 3; p++) begin
            if (a == 8'hC0 + 8'(p)) m_latch[p] = d;
            if (a == 8'hC4 + 8'(p)) m_dir[p] = d;
        end
    endtask

    // Inputs change at negedge; the posedge in between samples them.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [7:0] e;
        e = exp_read(a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, {24'h0, bus_rdata}, {24'h0, e});
    endtask

    task automatic check_pins(input string req);
        check({req, " pu"},  {8'h0, pin_pu_en}, {8'h0, exp_pu()});
        check({req, " oe"},  {8'h0, pin_oe},    {8'h0, exp_oe()});
        check({req, " out"}, {8'h0, pin_out},   {8'h0, exp_out()});
    endtask

    task automatic set_pins(input logic [23:0] v);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v, old;
        void'($urandom(32'd2024));
        m_latch[0] = 8'h00; m_latch[1] = 8'h00; m_latch[2] = 8'h04;
        m_dir[0]   = 8'h00; m_dir[1]   = 8'h00; m_dir[2]   = 8'h04;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and pin state
        check_pins("R1");
        rd(8'hC4, "R1 dirA"); rd(8'hC5, "R1 dirB"); rd(8'hC6, "R1 dirC");
        rd(8'hC2, "R1 latchC");
        check("R1 pc2 released", {31'h0, pin_oe[18]}, 32'h0);

        // R6: pad change needs two sync stages
        pin_in = 24'h0000A5;
        bus_addr = 8'hC0; bus_rd = 1'b1;   // sampled at first edge: old level
        @(negedge clk);
        bus_rd = 1'b0;
        check("R6 first edge", {24'h0, bus_rdata}, 32'h0);
        @(negedge clk);
        rd(8'hC0, "R6 third edge");

        // R2/R3/R4: directions and open-drain
        wr(8'hC4, 8'h0F); rd(8'hC4, "R2 dirA");
        wr(8'hC0, 8'h35); check_pins("R3 R4 mixed");
        rd(8'hC0, "R5 mixed readback");

        // R7: read-modify-write of bit 1 flips pull-ups of input bits
        set_pins(24'h0000F0);
        wr(8'hC0, 8'h00);
        check("R7 pu before", {24'h0, pin_pu_en[7:0]}, 32'h000000F0);
        rd(8'hC0, "R7 rmw read");
        v = exp_read(8'hC0) | 8'h02;
        wr(8'hC0, v);
        check("R7 pu after", {24'h0, pin_pu_en[7:0]}, 32'h00000000);
        check_pins("R7");

        // R8: unmapped addresses
        wr(8'hC3, 8'hFF); wr(8'hC7, 8'hFF); wr(8'h00, 8'hFF);
        check_pins("R8 ignored write");
        rd(8'hC3, "R8 C3"); rd(8'hC7, "R8 C7"); rd(8'hFF, "R8 FF");

        // R9: rdata holds without strobe
        rd(8'hC6, "R9 read");
        old = bus_rdata;
        bus_addr = 8'hC4;
        repeat (3) @(negedge clk);
        check("R9 hold", {24'h0, bus_rdata}, {24'h0, old});

        // R10: read and write of same address in one cycle
        old = m_dir[1];
        bus_addr = 8'hC5; bus_wdata = 8'h5A; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(8'hC5, 8'h5A);
        check("R10 old value", {24'h0, bus_rdata}, {24'h0, old});
        check_pins("R10 new value");

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            logic [7:0] a;
            op = $urandom % 4;
            a = 8'hC0 + 8'($urandom % 8);
            if (($urandom % 8) == 0) a = 8'($urandom);
            case (op)
                0: begin wr(a, 8'($urandom)); check_pins("R3 R4 R7 random"); end
                1: rd(a, "R2 R5 R8 random");
                2: set_pins(24'($urandom));
                default: @(negedge clk);
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule